// File: doc/BRIEF.md
# Double-Buffered SPI Host Controller

This block is a full-duplex SPI host for one serial device. A processor-side register interface gives a transmit holding register, a receive holding register and a set of status flags. One shift register is shared by both directions. Each bit driven on MOSI is paired with one MISO sample, so a byte arrives only when a byte is sent. The bus runs in mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. Frames are 8 bits, most significant bit first.

A write when the controller is idle goes straight into the shift register and starts a frame. A write during a frame waits in the holding register. When the frame finishes, the received byte goes to the receive register and the waiting byte starts the next frame. Chip select stays low between chained frames. After each frame the controller waits a programmable number of system clocks before it either chains the next frame or releases chip select. The serial clock half period is `clk_div + 1` system clocks.

The control state machine has four states. `ST_IDLE`: chip select is high. `ST_LEAD`: chip select is low and the clock is held low for one half period. `ST_SHIFT`: eight clock periods. `ST_GAP`: the post-frame delay. The transitions are:
- *start*: `ST_IDLE`→`ST_LEAD` on a write.
- *lead_done*: `ST_LEAD`→`ST_SHIFT` on the half-period tick.
- *frame_wait*: `ST_SHIFT`→`ST_GAP` at the end of a frame when the delay is nonzero.
- *chain*: `ST_SHIFT` or `ST_GAP`→`ST_LEAD` when data is pending.
- *stop*: `ST_SHIFT` or `ST_GAP`→`ST_IDLE` when nothing is pending.

Top module: `spi_dbuf_host`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `tx_empty`=1, `xfer_done`=1, `rx_full`=0 and `overrun`=0.
- R2: A `wr_tx` pulse while idle pulls `cs_n` low. The first rising `sck` edge comes `clk_div+1` clocks later. `wr_data` is sent on MOSI MSB first, with each bit stable across its rising edge.
- R3: MISO is sampled on each rising `sck` edge. The eight samples, first sample as bit 7, form the byte presented on `rx_data`.
- R4: A `wr_tx` during a frame leaves the byte waiting and drops `tx_empty` on the next clock. `tx_empty` rises again when the waiting byte moves into the shift register. `tx_dma_req` always equals `tx_empty`.
- R5: A waiting byte is sent in the next frame without further writes, and `cs_n` stays low between the two frames.
- R6: `xfer_done` falls when a frame starts from idle. It rises, with `cs_n` going high, exactly `gap_len` clocks after the last falling `sck` edge of the final frame (in the same clock when `gap_len`=0).
- R7: `rx_full` rises when a received byte lands and falls only on an `rd_rx` pulse. `rd_stat` leaves it unchanged.
- R8: A byte landing while `rx_full`=1 (with no `rd_rx` in that clock) sets `overrun` and overwrites `rx_data`. `overrun` falls only on an `rd_stat` pulse; `rd_rx` leaves it set.
- R9: `sck` is low whenever `cs_n` is high, and each high phase of `sck` lasts `clk_div+1` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | Serial half period minus one, in system clocks |
| gap_len | input | 8 | Post-frame delay in system clocks, 0 = none |
| wr_tx | input | 1 | One-clock write strobe for the transmit register |
| wr_data | input | 8 | Transmit byte |
| rd_rx | input | 1 | One-clock strobe marking a read of the receive register |
| rd_stat | input | 1 | One-clock strobe marking a read of the status flags |
| rx_data | output | 8 | Receive holding register |
| tx_empty | output | 1 | Transmit register can take a byte |
| xfer_done | output | 1 | No frame in progress or pending |
| rx_full | output | 1 | Unread byte in receive register |
| overrun | output | 1 | A received byte overwrote an unread one |
| tx_dma_req | output | 1 | Transmit DMA request level |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume several things about the inputs. `clk_div` and `gap_len` are held constant while `xfer_done` is low. Strobes last one clock. `rd_rx` does not coincide with a byte landing in the receive register. The stimulus changes the configuration only between idle periods. It drives every strobe for a single clock on the falling edge of `clk`, and it issues reads only after `xfer_done` has risen. The device model changes MISO on falling `sck` edges, so MISO is stable at every rising edge where the design samples it.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } host_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [GW-1:0] len,
    output logic          expire
);
    logic [GW-1:0] cnt_q;

    assign expire = run && (cnt_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          sample,
    input  logic          shift,
    input  logic          sdi,
    output logic          sdo,
    output logic [DW-1:0] next_word
);
    logic [DW-1:0] sr_q;
    logic          samp_q;

    assign next_word = {sr_q[DW-2:0], samp_q};
    assign sdo       = sr_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            samp_q <= 1'b0;
        end else begin
            if (load)       sr_q <= load_val;
            else if (shift) sr_q <= next_word;
            if (sample)     samp_q <= sdi;
        end
    end
endmodule

// File: rtl/spi_dbuf_host.sv
module spi_dbuf_host
    import spi_host_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] clk_div,
    input  logic [GW-1:0] gap_len,
    input  logic          wr_tx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_rx,
    input  logic          rd_stat,
    output logic [DW-1:0] rx_data,
    output logic          tx_empty,
    output logic          xfer_done,
    output logic          rx_full,
    output logic          overrun,
    output logic          tx_dma_req,
    output logic          cs_n,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    host_state_t st_q, st_d;

    logic [DW-1:0]  hold_q, rx_q, next_word, load_val;
    logic [BCW-1:0] bits_q;
    logic           ph_q, pend_q, txe_q, done_q, rxf_q, ovr_q;
    logic           tick, gap_exp, frame_end, finish, pend_eff;
    logic           start_idle, chain, stop, sh_load, sh_sample, sh_shift;

    spi_half_tick #(.CW(CW)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .run(st_q == ST_LEAD || st_q == ST_SHIFT),
        .limit(clk_div), .tick(tick)
    );

    spi_gap_timer #(.GW(GW)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .run(st_q == ST_GAP), .len(gap_len), .expire(gap_exp)
    );

    spi_shift_reg #(.DW(DW)) u_sr (
        .clk(clk), .rst_n(rst_n),
        .load(sh_load), .load_val(load_val),
        .sample(sh_sample), .shift(sh_shift),
        .sdi(miso), .sdo(mosi), .next_word(next_word)
    );

    // event decode
    always_comb begin
        frame_end  = (st_q == ST_SHIFT) && tick && ph_q && (bits_q == LAST_BIT);
        finish     = (frame_end && (gap_len == '0)) || gap_exp;
        pend_eff   = pend_q || wr_tx;
        start_idle = (st_q == ST_IDLE) && wr_tx;
        chain      = finish && pend_eff;
        stop       = finish && !pend_eff;
        sh_load    = start_idle || chain;
        load_val   = wr_tx ? wr_data : hold_q;
        sh_sample  = tick && ((st_q == ST_LEAD) || (st_q == ST_SHIFT && !ph_q));
        sh_shift   = (st_q == ST_SHIFT) && tick && ph_q;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (wr_tx) st_d = ST_LEAD;
            ST_LEAD:  if (tick)  st_d = ST_SHIFT;
            ST_SHIFT: if (frame_end) begin
                          if (gap_len != '0) st_d = ST_GAP;
                          else               st_d = pend_eff ? ST_LEAD : ST_IDLE;
                      end
            ST_GAP:   if (gap_exp) st_d = pend_eff ? ST_LEAD : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rx_q   <= '0;
            bits_q <= '0;
            ph_q   <= 1'b0;
            pend_q <= 1'b0;
            txe_q  <= 1'b1;
            done_q <= 1'b1;
            rxf_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (st_q == ST_LEAD && tick)       ph_q <= 1'b1;
            else if (st_q == ST_SHIFT && tick) ph_q <= ~ph_q;

            if (frame_end)     bits_q <= '0;
            else if (sh_shift) bits_q <= bits_q + 1'b1;

            if (sh_load) begin
                txe_q  <= 1'b1;
                pend_q <= 1'b0;
            end else if (wr_tx) begin
                hold_q <= wr_data;
                pend_q <= 1'b1;
                txe_q  <= 1'b0;
            end

            if (start_idle) done_q <= 1'b0;
            else if (stop)  done_q <= 1'b1;

            if (frame_end) begin
                rx_q  <= next_word;
                rxf_q <= 1'b1;
            end else if (rd_rx) begin
                rxf_q <= 1'b0;
            end

            if (frame_end && rxf_q && !rd_rx) ovr_q <= 1'b1;
            else if (rd_stat)                 ovr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cs_n       = (st_q == ST_IDLE);
        sck        = (st_q == ST_SHIFT) && ph_q;
        rx_data    = rx_q;
        tx_empty   = txe_q;
        tx_dma_req = txe_q;
        xfer_done  = done_q;
        rx_full    = rxf_q;
        overrun    = ovr_q;
    end

    p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    p_done_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> cs_n);
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_stat) |=> overrun);
    p_rxf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_rx) |=> rx_full);
    p_txe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && st_q != ST_IDLE && !finish) |=> !tx_empty);
    p_cs_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && pend_q) |=> !cs_n);
endmodule

// File: tb/sim_spi_dbuf_host.sv
`timescale 1ns/1ps
module sim_spi_dbuf_host;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] clk_div = 8'd2, gap_len = 8'd0, wr_data = 8'd0;
    logic       wr_tx = 1'b0, rd_rx = 1'b0, rd_stat = 1'b0, miso = 1'b0;
    logic [7:0] rx_data;
    logic       tx_empty, xfer_done, rx_full, overrun, tx_dma_req, cs_n, sck, mosi;

    int vec = 0, bad = 0;

    spi_dbuf_host u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .gap_len(gap_len),
        .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rd_stat(rd_stat),
        .rx_data(rx_data), .tx_empty(tx_empty), .xfer_done(xfer_done),
        .rx_full(rx_full), .overrun(overrun), .tx_dma_req(tx_dma_req),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;

    // serial device model
    logic [7:0] sq [8];
    logic [7:0] rq [8];
    logic [7:0] rsh;
    int sidx = 0, sbit = 0, rcnt = 0, rbits = 0, cs_rises = 0;
    realtime t_csfall, t_rise, t_fall, t_done, hi_len, lead_len;
    bit first_rise;

    always @(negedge cs_n) begin
        t_csfall = $realtime; first_rise = 1'b1; sbit = 0; rbits = 0;
        miso = sq[sidx][7];
    end
    always @(posedge cs_n) cs_rises++;
    always @(posedge sck) begin
        t_rise = $realtime;
        if (first_rise) begin lead_len = t_rise - t_csfall; first_rise = 1'b0; end
        rsh = {rsh[6:0], mosi}; rbits++;
        if (rbits == 8) begin rq[rcnt] = rsh; rcnt++; rbits = 0; end
    end
    always @(negedge sck) begin
        t_fall = $realtime; hi_len = t_fall - t_rise;
        sbit++;
        if (sbit == 8) begin sbit = 0; sidx++; end
        miso = sq[sidx % 8][7 - sbit];
    end
    always @(posedge xfer_done) t_done = $realtime;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        wr_data = d; wr_tx = 1'b1;
        @(negedge clk); wr_tx = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk); @(negedge clk);
        while (!xfer_done && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, "watchdog", n, 0);
    endtask

    task automatic t_reset();
        chk(cs_n == 1 && sck == 0, "R1 bus idle", {cs_n, sck}, 2'b10);
        chk(tx_empty && xfer_done && !rx_full && !overrun, "R1 flags",
            {tx_empty, xfer_done, rx_full, overrun}, 4'b1100);
    endtask

    task automatic t_single();
        sidx = 0; rcnt = 0; sq[0] = 8'h3C;
        pulse_wr(8'hA5);
        chk(!cs_n && !xfer_done, "R6 start clears done", {cs_n, xfer_done}, 0);
        wait_idle();
        chk(rq[0] == 8'hA5, "R2 mosi byte", rq[0], 8'hA5);
        chk(lead_len == 60.0, "R2 lead half period", int'(lead_len), 60);
        chk(rx_data == 8'h3C, "R3 rx byte", rx_data, 8'h3C);
        chk(hi_len == 60.0, "R9 sck high time", int'(hi_len), 60);
        chk(t_done == t_fall, "R6 done no gap", int'(t_done - t_fall), 0);
        chk(rx_full && !overrun, "R7 rx_full set", {rx_full, overrun}, 2'b10);
        rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
        chk(rx_full, "R7 rd_stat keeps rx_full", rx_full, 1);
        rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0;
        chk(!rx_full, "R7 rd_rx clears", rx_full, 0);
    endtask

    task automatic t_chain();
        int r0;
        sidx = 0; rcnt = 0; sq[0] = 8'hC3; sq[1] = 8'h5A;
        r0 = cs_rises;
        pulse_wr(8'h11);
        pulse_wr(8'h22);
        chk(!tx_empty && !tx_dma_req, "R4 tx_empty drops", {tx_empty, tx_dma_req}, 0);
        wait_idle();
        chk(tx_empty && tx_dma_req, "R4 tx_empty back", {tx_empty, tx_dma_req}, 2'b11);
        chk(rq[0] == 8'h11 && rq[1] == 8'h22, "R5 chained bytes", {rq[0], rq[1]}, 16'h1122);
        chk(cs_rises - r0 == 1, "R5 cs held low", cs_rises - r0, 1);
        chk(overrun && rx_data == 8'h5A, "R8 overrun overwrite", {overrun, rx_data}, 9'h15A);
        rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0;
        chk(overrun && !rx_full, "R8 rd_rx keeps overrun", {overrun, rx_full}, 2'b10);
        rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
        chk(!overrun, "R8 rd_stat clears", overrun, 0);
    endtask

    task automatic t_gap();
        gap_len = 8'd20; clk_div = 8'd4;
        sidx = 0; rcnt = 0; sq[0] = 8'h81;
        pulse_wr(8'h7E);
        wait_idle();
        chk(t_done - t_fall == 400.0, "R6 gap delay", int'(t_done - t_fall), 400);
        chk(hi_len == 100.0, "R9 sck high div4", int'(hi_len), 100);
        chk(rq[0] == 8'h7E && rx_data == 8'h81, "R3 gap frame", {rq[0], rx_data}, 16'h7E81);
        chk(cs_n && !sck, "R9 idle after gap", {cs_n, sck}, 2'b10);
        rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0;
        gap_len = 8'd0; clk_div = 8'd2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_gap();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #3000000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule